// File: doc/BRIEF.md
# Clock-Rate Switch and Core Restart Sequencer

This block holds the setup register of a network controller core and sequences the core through one optional change of its clock rate. After a hardware reset the core runs from the 20 MHz base clock, which supports data rates up to 2.5 Mbps. The host may select the doubled 40 MHz clock, which supports rates up to 5 Mbps. When it does, the block stops the core, powers up the clock multiplier and counts out the multiplier's lock time. The core stays stopped until the host writes the restart command value 0x18 to the command register.

The host reaches the block through a simple write port. One address bit picks between the setup register and the command register. The setup register can always be read back on a separate output. The clock select may change only once per hardware reset, and a sticky flag shows when that one change has been used. The multiplier is modelled as a lock-delay counter. Its default length of 400 cycles is 8 us at the 50 MHz control clock. The recommended host sequence is: reset, change the select bit, wait about 1 ms, write 0x18, then run the normal initialisation.

A second setup bit enables fast read timing. It takes effect only while an external bus-timing input is high, and it has no effect on writes.

Top module: `clk_rate_seq`

## Requirements
- R1: After reset the outputs are: `setup_rd` = 0x00, `clk_sel` = 0, `mult_pwr` = 0, `lock` = 0, `sel_used` = 0 and `core_run` = 1.
- R2: A write with `wr_addr`=0 stores the setup register. Bit 7 is the fast-read enable, bit 4 is the clock select and bits 3..0 are general setup bits. All of them read back on `setup_rd` one cycle later. Bits 6 and 5 always read 0. `clk_sel` shows bit 4.
- R3: The first setup write after reset whose bit 4 differs from `clk_sel` has these effects on the next cycle: `clk_sel` takes the new value, and `core_run` = 0, `mult_pwr` = 1 and `sel_used` = 1.
- R4: Once `sel_used` = 1, a setup write never changes bit 4, although its other bits are still stored. Such a write leaves `core_run` and `mult_pwr` unchanged. `sel_used` stays 1 until reset.
- R5: A setup write whose bit 4 equals the current `clk_sel` leaves `core_run` and `mult_pwr` unchanged.
- R6: `lock` rises exactly LOCK_CYCLES cycles after the clock edge that takes the select-changing write. It then stays high until reset.
- R7: The restart command is a write with `wr_addr`=1 and data 0x18. If it arrives while the core is stopped and `lock` is 1, `core_run` goes to 1 on the next cycle.
- R8: If the restart command arrives while the core is stopped and `lock` is still 0, it is remembered. `core_run` then goes to 1 one cycle after `lock` rises, and not before.
- R9: A command write with any value other than 0x18 never restarts the core. A command write of 0x18 while `core_run` = 1 has no effect. Command writes never alter the setup register.
- R10: `fast_read_en` = setup bit 7 AND `bus_fast_in`, at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 1 | Register select: 0 = setup, 1 = command |
| wr_data | input | 8 | Host write data |
| bus_fast_in | input | 1 | External bus-timing input that qualifies fast reads |
| setup_rd | output | 8 | Setup register readback |
| fast_read_en | output | 1 | Fast read timing active |
| clk_sel | output | 1 | Clock select: 0 = 20 MHz base, 1 = 40 MHz doubled |
| mult_pwr | output | 1 | Clock multiplier power enable |
| lock | output | 1 | Multiplier lock reached |
| sel_used | output | 1 | Sticky: the one permitted select change has been used |
| core_run | output | 1 | Core operation enable |

## Verification
Each fault in the internal state shows up at the ports. If the sticky flag is corrupted, a later write can flip `clk_sel` back, and this is visible in `setup_rd` one cycle after that write. If the lock counter is off, the rising edge of `lock` moves away from its exact cycle. If a remembered restart request is lost or set without cause, `core_run` rises one cycle after lock when it should not, or fails to rise when it should. The bench samples these outputs on the exact cycle where each should change and also one cycle before it.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    // Setup register layout
    typedef struct packed {
        logic       fast_rd;   // bit 7: fast read enable
        logic [1:0] rsvd;      // bits 6..5: always zero
        logic       clk_sel;   // bit 4: clock select
        logic [3:0] gen;       // bits 3..0: general setup bits
    } setup_t;

    typedef enum logic {
        SEQ_RUN  = 1'b0,
        SEQ_HALT = 1'b1
    } seq_state_t;

    localparam logic [7:0] CMD_RESTART = 8'h18;
    localparam logic       ADDR_SETUP  = 1'b0;
    localparam logic       ADDR_CMD    = 1'b1;

    // Turn raw write data into a setup value with the reserved bits cleared
    function automatic setup_t to_setup(input logic [7:0] d);
        setup_t s;
        s      = setup_t'(d);
        s.rsvd = 2'b00;
        return s;
    endfunction

    function automatic logic is_restart(input logic en, input logic addr,
                                        input logic [7:0] d);
        return en && (addr == ADDR_CMD) && (d == CMD_RESTART);
    endfunction

endpackage

// File: rtl/clksw_cfg_reg.sv
module clksw_cfg_reg
    import clksw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_setup,
    input  logic [7:0] wr_data,
    output setup_t     setup_q,
    output logic       sel_used,
    output logic       sel_change
);
    setup_t incoming;
    setup_t next_val;

    always_comb begin
        incoming   = to_setup(wr_data);
        sel_change = wr_setup && !sel_used && (incoming.clk_sel != setup_q.clk_sel);
        next_val   = incoming;
        // Once the single change is spent, the select bit is frozen
        if (sel_used) next_val.clk_sel = setup_q.clk_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q  <= '0;
            sel_used <= 1'b0;
        end else begin
            if (wr_setup)   setup_q  <= next_val;
            if (sel_change) sel_used <= 1'b1;
        end
    end
endmodule

// File: rtl/clksw_lock_timer.sv
module clksw_lock_timer #(
    parameter int LOCK_CYCLES = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic mult_pwr,
    output logic lock
);
    localparam int CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mult_pwr <= 1'b0;
            lock     <= 1'b0;
            cnt      <= '0;
        end else if (start) begin
            mult_pwr <= 1'b1;
            lock     <= 1'b0;
            cnt      <= '0;
        end else if (mult_pwr && !lock) begin
            if (cnt == LAST) lock <= 1'b1;
            else             cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/clksw_restart_fsm.sv
module clksw_restart_fsm
    import clksw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel_change,
    input  logic restart_wr,
    input  logic lock,
    output logic core_run
);
    seq_state_t state;
    logic       pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_RUN;
            pend  <= 1'b0;
        end else if (sel_change) begin
            state <= SEQ_HALT;
            pend  <= 1'b0;
        end else if (state == SEQ_HALT) begin
            if (lock && (pend || restart_wr)) begin
                state <= SEQ_RUN;
                pend  <= 1'b0;
            end else if (restart_wr) begin
                pend <= 1'b1;
            end
        end
    end

    assign core_run = (state == SEQ_RUN);
endmodule

// File: rtl/clk_rate_seq.sv
module clk_rate_seq
    import clksw_pkg::*;
#(
    parameter int LOCK_CYCLES = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       bus_fast_in,
    output logic [7:0] setup_rd,
    output logic       fast_read_en,
    output logic       clk_sel,
    output logic       mult_pwr,
    output logic       lock,
    output logic       sel_used,
    output logic       core_run
);
    setup_t setup_q;
    logic   sel_change;
    logic   restart_wr;
    logic   wr_setup;

    assign wr_setup   = wr_en && (wr_addr == ADDR_SETUP);
    assign restart_wr = is_restart(wr_en, wr_addr, wr_data);

    clksw_cfg_reg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_setup   (wr_setup),
        .wr_data    (wr_data),
        .setup_q    (setup_q),
        .sel_used   (sel_used),
        .sel_change (sel_change)
    );

    clksw_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (sel_change),
        .mult_pwr (mult_pwr),
        .lock     (lock)
    );

    clksw_restart_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sel_change (sel_change),
        .restart_wr (restart_wr),
        .lock       (lock),
        .core_run   (core_run)
    );

    assign setup_rd     = setup_q;
    assign clk_sel      = setup_q.clk_sel;
    assign fast_read_en = setup_q.fast_rd & bus_fast_in;
endmodule

// File: rtl/clk_rate_seq_chk.sv
module clk_rate_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_addr,
    input logic [7:0] wr_data,
    input logic       bus_fast_in,
    input logic [7:0] setup_rd,
    input logic       fast_read_en,
    input logic       clk_sel,
    input logic       mult_pwr,
    input logic       lock,
    input logic       sel_used,
    input logic       core_run
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        setup_rd[6:5] == 2'b00);  // R2

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (rst)
        sel_used |=> ($stable(clk_sel) && sel_used));  // R4

    AST_HALT_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr && (wr_data[4] != clk_sel) && !sel_used)
            |=> (!core_run && mult_pwr));  // R3

    AST_SAME_SEL_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr && (wr_data[4] == clk_sel) && core_run) |=> core_run);  // R5

    AST_NO_RUN_BEFORE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (mult_pwr && !lock) |-> !core_run);  // R8

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);  // R6

    AST_MULT_OFF_UNTIL_USED: assert property (@(posedge clk) disable iff (rst)
        !sel_used |-> !mult_pwr);  // R1

    AST_FAST_READ_GATE: assert property (@(posedge clk) disable iff (rst)
        fast_read_en == (setup_rd[7] && bus_fast_in));  // R10
endmodule

bind clk_rate_seq clk_rate_seq_chk chk_i (.*);

// File: tb/clk_rate_seq_tb_top.sv
module clk_rate_seq_tb_top;
    localparam int L = 20;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, wr_addr, bus_fast_in;
    logic [7:0] wr_data;
    logic [7:0] setup_rd;
    logic       fast_read_en, clk_sel, mult_pwr, lock, sel_used, core_run;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    clk_rate_seq #(.LOCK_CYCLES(L)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bus_fast_in(bus_fast_in), .setup_rd(setup_rd),
        .fast_read_en(fast_read_en), .clk_sel(clk_sel), .mult_pwr(mult_pwr),
        .lock(lock), .sel_used(sel_used), .core_run(core_run)
    );

    function automatic logic [7:0] exp_rd(input logic [7:0] d);
        return d & 8'h9F;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called right after a falling edge; the write is taken at the next rising edge
    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    task automatic chk_reset_state();
        chk("R1 setup_rd", setup_rd, 8'h00);
        chk("R1 clk_sel", {7'd0, clk_sel}, 8'd0);
        chk("R1 mult_pwr", {7'd0, mult_pwr}, 8'd0);
        chk("R1 lock", {7'd0, lock}, 8'd0);
        chk("R1 sel_used", {7'd0, sel_used}, 8'd0);
        chk("R1 core_run", {7'd0, core_run}, 8'd1);
    endtask

    initial begin
        logic [7:0] shadow;
        logic [7:0] v;
        rst = 1'b1; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00; bus_fast_in = 1'b0;
        void'($urandom(32'd20241));
        @(negedge clk);
        do_reset();
        chk_reset_state();

        // Random setup writes that keep the select bit, plus command writes while running
        shadow = 8'h00;
        for (int i = 0; i < 40; i++) begin
            bus_fast_in = 1'($urandom % 2);
            if ($urandom % 3 == 0) begin
                v = (i % 5 == 0) ? 8'h18 : 8'($urandom);
                wr(1'b1, v);
                chk("R9 cmd while running keeps core_run", {7'd0, core_run}, 8'd1);
            end else begin
                v = 8'($urandom) & 8'hEF;
                shadow = v;
                wr(1'b0, v);
                chk("R5 same select keeps mult_pwr off", {7'd0, mult_pwr}, 8'd0);
                chk("R5 same select keeps core_run", {7'd0, core_run}, 8'd1);
            end
            chk("R2 readback", setup_rd, exp_rd(shadow));
            chk("R10 fast_read_en", {7'd0, fast_read_en}, {7'd0, shadow[7] & bus_fast_in});
        end

        // Scenario A: change, ignored revert, lock timing, restart after lock
        wr(1'b0, 8'h9D);
        chk("R3 clk_sel", {7'd0, clk_sel}, 8'd1);
        chk("R3 core_run", {7'd0, core_run}, 8'd0);
        chk("R3 mult_pwr", {7'd0, mult_pwr}, 8'd1);
        chk("R3 sel_used", {7'd0, sel_used}, 8'd1);
        chk("R2 readback after change", setup_rd, 8'h9D);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h17);
        wr(1'b1, 8'h81);
        chk("R9 bad cmds do not restart", {7'd0, core_run}, 8'd0);
        chk("R9 cmd leaves setup", setup_rd, 8'h9D);
        wr(1'b0, 8'h0A);  // would clear the select bit: only bits 7 and 3..0 are taken
        chk("R4 select frozen", setup_rd, 8'h1A);
        chk("R4 clk_sel", {7'd0, clk_sel}, 8'd1);
        idle(L - 1 - 4);
        chk("R6 lock not yet", {7'd0, lock}, 8'd0);
        idle(1);
        chk("R6 lock at L", {7'd0, lock}, 8'd1);
        chk("R7 still halted without cmd", {7'd0, core_run}, 8'd0);
        idle(3);
        chk("R7 halted waits for cmd", {7'd0, core_run}, 8'd0);
        wr(1'b1, 8'h18);
        chk("R7 restart after lock", {7'd0, core_run}, 8'd1);
        idle(5);
        chk("R6 lock sticky", {7'd0, lock}, 8'd1);
        chk("R7 stays running", {7'd0, core_run}, 8'd1);

        // Scenario B: early restart request is remembered
        do_reset();
        chk_reset_state();
        wr(1'b0, 8'h10);
        idle(1);
        wr(1'b1, 8'h18);
        chk("R8 early cmd does not restart", {7'd0, core_run}, 8'd0);
        idle(L - 1 - 2);
        chk("R8 before lock", {7'd0, lock}, 8'd0);
        chk("R8 before lock halted", {7'd0, core_run}, 8'd0);
        idle(1);
        chk("R8 lock rises", {7'd0, lock}, 8'd1);
        chk("R8 halted on lock cycle", {7'd0, core_run}, 8'd0);
        idle(1);
        chk("R8 released one cycle after lock", {7'd0, core_run}, 8'd1);
        wr(1'b0, 8'h00);
        chk("R4 revert ignored", {7'd0, clk_sel}, 8'd1);
        chk("R4 revert keeps core_run", {7'd0, core_run}, 8'd1);
        chk("R4 revert keeps mult_pwr", {7'd0, mult_pwr}, 8'd1);
        wr(1'b1, 8'h18);
        chk("R9 restart while running no effect", {7'd0, core_run}, 8'd1);
        bus_fast_in = 1'b1;
        wr(1'b0, 8'h80);
        chk("R10 fast read on", {7'd0, fast_read_en}, 8'd1);
        bus_fast_in = 1'b0;
        #1;
        chk("R10 fast read gated", {7'd0, fast_read_en}, 8'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule